// File: doc/BRIEF.md
# Single-Cycle Eight-Register Processor Core

This block is a small processor core that finishes every instruction in one clock. A program counter addresses an instruction port. The fetched word is decoded by combinational control logic. Two operands come out of an eight-entry, 32-bit register file. The result is written back on the next rising edge. The core uses three separate adders: one makes the sequential next address, one makes the branch destination and one sits inside the ALU. There is no shared adder and no multi-cycle sequencing.

Instruction and data storage sit outside the block. Each is reached through a word-addressed port with a combinational read. The data port also has a write strobe that takes effect on the clock edge, so a surrounding model can implement either memory as a plain array. The instruction set has eight opcodes: two register-to-register operations, a load, a store, a compare-and-branch, a jump that saves a return address, a stop instruction and an empty instruction. The stop instruction freezes the core and raises a flag that stays set until reset.

Instruction word layout: opcode in bits 24..22, first source field (A) in bits 21..19, second field (B) in bits 18..16, destination field in bits 2..0, and a 16-bit two's-complement offset in bits 15..0. Bits above 24 are ignored.

Top module: `tiny_core`

## Requirements
- R1: While reset is low, the instruction address is 0, the halted flag is 0 and all eight registers read 0. Reset is asynchronous and active low.
- R2: Opcode 000 writes the 32-bit wrapping sum of register A and register B into the destination register. The next instruction address is the current one plus 1.
- R3: Opcode 001 writes the bitwise NOR of register A and register B into the destination register. The next instruction address is the current one plus 1.
- R4: Opcode 010 loads the data word at register A plus the sign-extended offset into register B. This holds for negative offsets too.
- R5: Opcode 011 raises the data write strobe and presents register B as write data, at address register A plus the sign-extended offset. No register changes. The strobe is high only for this opcode.
- R6: Opcode 100 sets the next address to current + 1 + sign-extended offset when register A equals register B, and to current + 1 otherwise. This includes backward branches.
- R7: Opcode 101 writes current + 1 into register B and sets the next address to the value of register A.
- R8: When opcode 101 names the same register in both fields, the next address is that register's value before the instruction, and the register then holds current + 1.
- R9: Opcode 110 keeps the instruction address where it is and sets the halted flag. From then until reset, the address stays frozen, no register is written and the data strobe stays low, whatever word is fetched.
- R10: Opcode 111 changes no register and no memory. It only advances the instruction address by 1.
- R11: Register 0 is an ordinary register: it can be written and read back like the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | IAW | Word address of the instruction being executed (the program counter) |
| imem_rdata | input | XLEN | Instruction word at imem_addr, combinational |
| dmem_addr | output | DAW | Data word address (ALU result) |
| dmem_wdata | output | XLEN | Store data (register B) |
| dmem_we | output | 1 | Store strobe, written on the rising edge |
| dmem_rdata | input | XLEN | Data word at dmem_addr, combinational |
| halted | output | 1 | Set by the stop instruction, cleared only by reset |

## Verification
The hardest situations to reach from the ports are a return-jump whose link and target fields name the same register, and a branch loop that runs backward. Both change internal register state, and that state is visible only through later stores. Directed programs cover them. The programs first load chosen constants and compute the jump targets from the known program layout. They then store every register to a known area, so the bench can read the results from the data array. Random programs of arithmetic, loads, stores and forward branches are compared cycle by cycle, on address and store strobe, against an instruction-level model in the bench. Stopping is checked by replacing the fetched word with a store while the core is halted and confirming that nothing moves.

// File: rtl/tiny_core_pkg.sv
package tiny_core_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'b000,
      OP_NOR  = 3'b001,
      OP_LW   = 3'b010,
      OP_SW   = 3'b011,
      OP_BEQ  = 3'b100,
      OP_JALR = 3'b101,
      OP_HALT = 3'b110,
      OP_NOOP = 3'b111
   } opcode_e;

   localparam int OPC_LSB = 22;
   localparam int OPC_W   = 3;
   localparam int RA_LSB  = 19;
   localparam int RB_LSB  = 16;
   localparam int RD_LSB  = 0;
   localparam int RF_W    = 3;
   localparam int OFF_W   = 16;
   localparam int TOP_BIT = OPC_LSB + OPC_W - 1;

   typedef enum logic [1:0] {
      WB_ALU  = 2'd0,
      WB_MEM  = 2'd1,
      WB_LINK = 2'd2
   } wb_sel_e;

   typedef struct packed {
      logic    reg_we;
      logic    dest_is_rd;
      wb_sel_e wb_sel;
      logic    alu_nor;
      logic    alu_imm;
      logic    mem_we;
      logic    is_beq;
      logic    is_jalr;
      logic    is_halt;
   } ctrl_t;

endpackage

// File: rtl/tiny_core_ctrl.sv
module tiny_core_ctrl
   import tiny_core_pkg::*;
(
   input  opcode_e opcode,
   output ctrl_t   ctl
);

   always_comb begin
      ctl = '0;
      unique case (opcode)
         OP_ADD: begin
            ctl.reg_we     = 1'b1;
            ctl.dest_is_rd = 1'b1;
            ctl.wb_sel     = WB_ALU;
         end
         OP_NOR: begin
            ctl.reg_we     = 1'b1;
            ctl.dest_is_rd = 1'b1;
            ctl.wb_sel     = WB_ALU;
            ctl.alu_nor    = 1'b1;
         end
         OP_LW: begin
            ctl.reg_we  = 1'b1;
            ctl.wb_sel  = WB_MEM;
            ctl.alu_imm = 1'b1;
         end
         OP_SW: begin
            ctl.mem_we  = 1'b1;
            ctl.alu_imm = 1'b1;
         end
         OP_BEQ:  ctl.is_beq = 1'b1;
         OP_JALR: begin
            ctl.reg_we  = 1'b1;
            ctl.wb_sel  = WB_LINK;
            ctl.is_jalr = 1'b1;
         end
         OP_HALT: ctl.is_halt = 1'b1;
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/tiny_core_regs.sv
module tiny_core_regs #(
   parameter int W  = 32,
   parameter int N  = 8,
   parameter int AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_a,
   output logic [W-1:0]  rdata_b
);

   logic [N-1:0]        sel;
   logic [N-1:0][W-1:0] bank;

   for (genvar i = 0; i < N; i++) begin : g_ent
      logic [W-1:0] q;
      assign sel[i] = we && (waddr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= '0;
         else if (sel[i]) q <= wdata;
      end
      assign bank[i] = q;
   end

   assign rdata_a = bank[raddr_a];
   assign rdata_b = bank[raddr_b];

endmodule

// File: rtl/tiny_core_alu.sv
module tiny_core_alu #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         do_nor,
   output logic [W-1:0] y,
   output logic         same
);

   assign y    = do_nor ? ~(a | b) : (a + b);
   assign same = (a == b);

endmodule

// File: rtl/tiny_core_pcgen.sv
module tiny_core_pcgen #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          halt_req,
   input  logic          take_br,
   input  logic          jump,
   input  logic [AW-1:0] jump_to,
   input  logic [AW-1:0] offset,
   output logic [AW-1:0] pc,
   output logic [AW-1:0] pc_inc,
   output logic          halted
);

   logic [AW-1:0] pc_q;
   logic [AW-1:0] br_dest;
   logic [AW-1:0] pc_nxt;
   logic          stop_q;

   assign pc_inc  = pc_q + AW'(1);
   assign br_dest = pc_inc + offset;

   always_comb begin
      if (stop_q || halt_req) pc_nxt = pc_q;
      else if (jump)          pc_nxt = jump_to;
      else if (take_br)       pc_nxt = br_dest;
      else                    pc_nxt = pc_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         stop_q <= 1'b0;
      end else begin
         pc_q   <= pc_nxt;
         stop_q <= stop_q | halt_req;
      end
   end

   assign pc     = pc_q;
   assign halted = stop_q;

endmodule

// File: rtl/tiny_core.sv
module tiny_core
   import tiny_core_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int IAW  = 16,
   parameter int DAW  = 16,
   parameter int NREG = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [IAW-1:0]  imem_addr,
   input  logic [XLEN-1:0] imem_rdata,
   output logic [DAW-1:0]  dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic            halted
);

   localparam int RIW = $clog2(NREG);

   initial begin
      assert (XLEN > TOP_BIT + 1) else $error("XLEN too small for the instruction layout");
      assert (NREG == (1 << RF_W)) else $error("register count must match the 3-bit fields");
      assert (IAW > 0 && IAW < XLEN) else $error("IAW out of range");
      assert (DAW > 0 && DAW < XLEN) else $error("DAW out of range");
      assert (XLEN > OFF_W) else $error("XLEN must exceed offset width");
   end

   opcode_e         opc;
   logic [RIW-1:0]  ra, rb, rd, waddr;
   logic [XLEN-1:0] imm;
   logic [XLEN-1:0] va, vb, alu_b, alu_y, wdata;
   logic            eq;
   logic            live;
   logic [IAW-1:0]  pc, pc_inc;
   ctrl_t           ctl;

   assign opc = opcode_e'(imem_rdata[OPC_LSB +: OPC_W]);
   assign ra  = imem_rdata[RA_LSB +: RIW];
   assign rb  = imem_rdata[RB_LSB +: RIW];
   assign rd  = imem_rdata[RD_LSB +: RIW];
   assign imm = {{(XLEN-OFF_W){imem_rdata[OFF_W-1]}}, imem_rdata[OFF_W-1:0]};

   tiny_core_ctrl u_ctrl (
      .opcode (opc),
      .ctl    (ctl)
   );

   tiny_core_regs #(.W(XLEN), .N(NREG), .AW(RIW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (ctl.reg_we && live),
      .waddr   (waddr),
      .wdata   (wdata),
      .raddr_a (ra),
      .raddr_b (rb),
      .rdata_a (va),
      .rdata_b (vb)
   );

   assign alu_b = ctl.alu_imm ? imm : vb;

   tiny_core_alu #(.W(XLEN)) u_alu (
      .a      (va),
      .b      (alu_b),
      .do_nor (ctl.alu_nor),
      .y      (alu_y),
      .same   (eq)
   );

   tiny_core_pcgen #(.AW(IAW)) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .halt_req (ctl.is_halt),
      .take_br  (ctl.is_beq && eq),
      .jump     (ctl.is_jalr),
      .jump_to  (va[IAW-1:0]),
      .offset   (imm[IAW-1:0]),
      .pc       (pc),
      .pc_inc   (pc_inc),
      .halted   (halted)
   );

   assign live  = !halted;
   assign waddr = ctl.dest_is_rd ? rd : rb;

   always_comb begin
      unique case (ctl.wb_sel)
         WB_MEM:  wdata = dmem_rdata;
         WB_LINK: wdata = XLEN'(pc_inc);
         default: wdata = alu_y;
      endcase
   end

   assign imem_addr  = pc;
   assign dmem_addr  = alu_y[DAW-1:0];
   assign dmem_wdata = vb;
   assign dmem_we    = ctl.mem_we && live;

   logic unused_bits;
   assign unused_bits = ^{imem_rdata[XLEN-1:TOP_BIT+1], alu_y[XLEN-1:DAW], va[XLEN-1:IAW]};

endmodule

// File: rtl/tiny_core_chk.sv
module tiny_core_chk #(
   parameter int IAW = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic [IAW-1:0] imem_addr,
   input logic [2:0]     opc,
   input logic           dmem_we,
   input logic           halted
);

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (imem_addr == '0 && !halted));

   assert_store_only_sw_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |-> (opc == 3'b011));

   assert_halt_enters_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && opc == 3'b110) |=> (halted && imem_addr == $past(imem_addr)));

   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(imem_addr)));

   assert_halt_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !dmem_we);

   assert_noop_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && opc == 3'b111) |=> (imem_addr == IAW'($past(imem_addr) + 1'b1)));

endmodule

bind tiny_core tiny_core_chk #(.IAW(IAW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .imem_addr (imem_addr),
   .opc       (imem_rdata[24:22]),
   .dmem_we   (dmem_we),
   .halted    (halted)
);

// File: tb/tiny_core_test.sv
module tiny_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] imem_addr;
   logic [31:0] imem_rdata;
   logic [15:0] dmem_addr;
   logic [31:0] dmem_wdata;
   logic        dmem_we;
   logic [31:0] dmem_rdata;
   logic        halted;

   logic [31:0] imem [256];
   logic [31:0] dmem [256];

   // reference model state
   logic [31:0] m_reg [8];
   logic [31:0] m_dmem [256];
   logic [15:0] m_pc;
   logic        m_halted;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int pp;
   bit done = 0;

   localparam logic [31:0] HALT_W = 32'h0180_0000;

   always #10 clk = ~clk;

   tiny_core uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata),
      .halted     (halted)
   );

   assign imem_rdata = imem[imem_addr[7:0]];
   assign dmem_rdata = dmem[dmem_addr[7:0]];

   always @(posedge clk) begin
      if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [31:0] enc_r(input logic [2:0] op, input int a, input int b, input int d);
      return {7'b0, op, 3'(a), 3'(b), 13'b0, 3'(d)};
   endfunction

   function automatic logic [31:0] enc_i(input logic [2:0] op, input int a, input int b, input int off);
      return {7'b0, op, 3'(a), 3'(b), 16'(off)};
   endfunction

   function automatic string tag_of(input logic [2:0] op);
      case (op)
         3'b000: return "R2";
         3'b001: return "R3";
         3'b010: return "R4";
         3'b011: return "R5";
         3'b100: return "R6";
         3'b101: return "R7";
         3'b110: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic emit(input logic [31:0] w);
      imem[pp[7:0]] = w;
      pp++;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) begin
         imem[i] = HALT_W;
         dmem[i] = '0;
      end
      pp = 0;
   endtask

   task automatic model_step();
      logic [31:0] ins, off, t;
      logic [2:0]  op;
      int a, b, d;
      ins = imem[m_pc[7:0]];
      op  = ins[24:22];
      a   = int'(ins[21:19]);
      b   = int'(ins[18:16]);
      d   = int'(ins[2:0]);
      off = {{16{ins[15]}}, ins[15:0]};
      if (m_halted) return;
      case (op)
         3'b000: begin m_reg[d] = m_reg[a] + m_reg[b]; m_pc = m_pc + 1; end
         3'b001: begin m_reg[d] = ~(m_reg[a] | m_reg[b]); m_pc = m_pc + 1; end
         3'b010: begin t = m_reg[a] + off; m_reg[b] = m_dmem[t[7:0]]; m_pc = m_pc + 1; end
         3'b011: begin t = m_reg[a] + off; m_dmem[t[7:0]] = m_reg[b]; m_pc = m_pc + 1; end
         3'b100: begin
            if (m_reg[a] == m_reg[b]) m_pc = m_pc + 16'd1 + off[15:0];
            else                      m_pc = m_pc + 1;
         end
         3'b101: begin t = m_reg[a]; m_reg[b] = {16'b0, m_pc + 16'd1}; m_pc = t[15:0]; end
         3'b110: m_halted = 1'b1;
         default: m_pc = m_pc + 1;
      endcase
   endtask

   // reset the core, run it against the model until both stop, compare the data image
   task automatic run_prog(input bit check_reset);
      logic [31:0] ins, off, ea;
      logic [2:0]  op, prev_op;
      rst_n = 1'b0;
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
      for (int i = 0; i < 256; i++) m_dmem[i] = dmem[i];
      m_pc = '0;
      m_halted = 1'b0;
      prev_op = 3'b111;
      repeat (2) @(posedge clk);
      @(negedge clk);
      if (check_reset) begin
         check(imem_addr == 16'd0, "R1", "address in reset", 32'(imem_addr), 32'd0);
         check(halted == 1'b0, "R1", "halted in reset", 32'(halted), 32'd0);
      end
      rst_n = 1'b1;
      for (int n = 0; n < 3000; n++) begin
         check(imem_addr == m_pc, tag_of(prev_op), "instruction address", 32'(imem_addr), 32'(m_pc));
         check(halted == m_halted, tag_of(prev_op), "halted flag", 32'(halted), 32'(m_halted));
         ins = imem[m_pc[7:0]];
         op  = ins[24:22];
         off = {{16{ins[15]}}, ins[15:0]};
         ea  = m_reg[ins[21:19]] + off;
         check(dmem_we == (!m_halted && op == 3'b011), "R5", "store strobe", 32'(dmem_we),
               32'(!m_halted && op == 3'b011));
         if (dmem_we && !m_halted && op == 3'b011) begin
            check(dmem_addr == ea[15:0], "R5", "store address", 32'(dmem_addr), 32'(ea[15:0]));
            check(dmem_wdata == m_reg[ins[18:16]], "R5", "store data", dmem_wdata, m_reg[ins[18:16]]);
         end
         if (m_halted && halted) break;
         prev_op = op;
         model_step();
         @(negedge clk);
      end
      for (int i = 0; i < 256; i++) begin
         if (dmem[i] !== m_dmem[i]) check(1'b0, "R2", $sformatf("data word %0d", i), dmem[i], m_dmem[i]);
      end
      check(1'b1, "R4", "data image compared", 32'd0, 32'd0);
   endtask

   task automatic gen_random(input int n);
      int k, a, b, d;
      clear_mem();
      for (int i = 0; i < 64; i++) dmem[i] = $urandom;
      for (int i = 7; i >= 0; i--) emit(enc_i(3'b010, 0, i, i));
      for (int i = 0; i < n; i++) begin
         k = $urandom_range(0, 5);
         a = $urandom_range(0, 7);
         b = $urandom_range(0, 7);
         d = $urandom_range(0, 7);
         case (k)
            0: emit(enc_r(3'b000, a, b, d));
            1: emit(enc_r(3'b001, a, b, d));
            2: emit(enc_i(3'b011, a, b, int'($urandom_range(0, 65535))));
            3: emit(enc_i(3'b010, a, b, int'($urandom_range(0, 65535))));
            4: emit(enc_i(3'b100, a, ($urandom_range(0, 3) == 0) ? a : b, int'($urandom_range(0, 3))));
            default: emit(enc_r(3'b111, a, b, d));
         endcase
      end
      for (int i = 0; i < 8; i++) emit(enc_i(3'b011, 7, i, 200 + i));
      emit(HALT_W);
   endtask

   initial begin
      int loop_pc, j1, j2, hpc;
      void'($urandom(32'd2718));
      clear_mem();

      // program 1: store reset contents, empty instruction, stop
      emit(enc_r(3'b111, 5, 6, 7));
      for (int i = 0; i < 8; i++) emit(enc_i(3'b011, 0, i, 100 + i));
      emit(HALT_W);
      run_prog(1'b1);
      for (int i = 0; i < 8; i++)
         check(dmem[100 + i] == 32'd0, "R1", $sformatf("register %0d after reset", i), dmem[100 + i], 32'd0);

      // program 2: directed corner cases
      clear_mem();
      dmem[10] = 32'd5;
      dmem[11] = 32'hFFFF_FFF0;
      dmem[12] = 32'd1;
      dmem[13] = 32'hFFFF_FFFF;
      dmem[14] = 32'd20;
      emit(enc_i(3'b010, 0, 1, 10));        // r1 = 5
      emit(enc_i(3'b010, 0, 4, 14));        // r4 = 20
      emit(enc_i(3'b010, 4, 3, -8));        // r3 = mem[12] = 1
      emit(enc_i(3'b010, 4, 2, -9));        // r2 = mem[11]
      emit(enc_r(3'b000, 1, 2, 0));         // r0 = r1 + r2
      emit(enc_r(3'b001, 1, 3, 5));         // r5 = ~(r1|r3)
      emit(enc_i(3'b011, 7, 5, 30));        // mem[30] = r5
      emit(enc_i(3'b011, 4, 0, -5));        // mem[15] = r0
      emit(enc_i(3'b010, 0, 6, 13));        // wrong base on purpose? r0 holds FFFFFFF5
      pp = pp - 1;
      emit(enc_i(3'b010, 7, 6, 13));        // r6 = -1
      loop_pc = pp;
      emit(enc_r(3'b000, 1, 6, 1));         // r1 = r1 - 1
      emit(enc_i(3'b100, 1, 7, 1));         // exit when r1 == 0
      emit(enc_i(3'b100, 7, 7, loop_pc - (pp + 1)));  // backward, always taken
      emit(enc_i(3'b100, 1, 3, 5));         // not taken (0 vs 1)
      j1 = pp + 1;
      emit(enc_i(3'b010, 7, 6, 16));        // r6 = target of first jump
      emit(enc_r(3'b101, 6, 5, 0));         // r5 = link, jump
      emit(HALT_W);                         // skipped
      dmem[16] = 32'(pp);
      emit(enc_i(3'b010, 7, 2, 17));        // r2 = target of second jump
      j2 = pp;
      emit(enc_r(3'b101, 2, 2, 0));         // same register for both fields
      emit(HALT_W);                         // skipped
      dmem[17] = 32'(pp);
      for (int i = 0; i < 8; i++) emit(enc_i(3'b011, 7, i, 40 + i));
      hpc = pp;
      emit(HALT_W);
      run_prog(1'b0);
      check(dmem[40] == 32'hFFFF_FFF5, "R11", "register 0 written by add", dmem[40], 32'hFFFF_FFF5);
      check(dmem[15] == 32'hFFFF_FFF5, "R2", "sum stored at negative offset", dmem[15], 32'hFFFF_FFF5);
      check(dmem[30] == 32'hFFFF_FFFA, "R3", "nor result", dmem[30], 32'hFFFF_FFFA);
      check(dmem[43] == 32'd1, "R4", "load with negative offset", dmem[43], 32'd1);
      check(dmem[41] == 32'd0, "R6", "backward loop count", dmem[41], 32'd0);
      check(dmem[45] == 32'(j1 + 1), "R7", "link value", dmem[45], 32'(j1 + 1));
      check(dmem[42] == 32'(j2 + 1), "R8", "same-register link", dmem[42], 32'(j2 + 1));
      check(imem_addr == 16'(hpc), "R8", "reached final stop", 32'(imem_addr), 32'(hpc));

      // stop freezes everything even when the fetched word changes
      imem[hpc] = enc_i(3'b011, 7, 1, 50);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(dmem_we == 1'b0, "R9", "no store while halted", 32'(dmem_we), 32'd0);
         check(imem_addr == 16'(hpc), "R9", "address frozen", 32'(imem_addr), 32'(hpc));
         check(halted == 1'b1, "R9", "flag held", 32'(halted), 32'd1);
      end
      imem[hpc] = enc_r(3'b000, 1, 1, 1);
      @(negedge clk);
      check(imem_addr == 16'(hpc), "R9", "address frozen on add", 32'(imem_addr), 32'(hpc));
      check(dmem[50] == 32'd0, "R9", "memory untouched", dmem[50], 32'd0);

      // random programs
      for (int r = 0; r < 6; r++) begin
         gen_random(40);
         run_prog(1'b0);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule